// File: doc/BRIEF.md
# Hybrid Skewed Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps four logical counter tables of 2-bit saturating counters. A bimodal table is indexed by the branch address alone. Two skewed tables hash the address with global history of two different lengths. A chooser table, also hashed with history, decides whether the final answer is the bimodal prediction or the majority vote of the bimodal and both skewed tables. The history that feeds the hashes mixes resolved branch outcomes with one address bit per branch, so it carries both outcome and path information.

A lookup is requested with `lk_valid` and `lk_pc`. The registered prediction appears on the next cycle, together with the history snapshot that indexed it. That snapshot is deliberately old: it is the global history as it stood three lookups earlier, which gives a fetch pipeline time to assemble it. The caller keeps the snapshot and returns it on the resolve port with the branch address and its real outcome. The counters are then trained in a single read-modify-write cycle. Each counter keeps its direction bit and its strength bit in two separate arrays. Lookups read only the direction array. Only the resolve stage reads the strength array.

Top module: `skew_vote_predictor`

## Requirements
- R1: Synchronous active-high reset sets every counter to weak not-taken (direction 0, strength 0) and clears the global history and all lag snapshots. Until the first resolve, every prediction is not-taken and reports history 0.
- R2: `pred_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and low otherwise. `pred_taken` and `pred_hist` are registered in that same cycle.
- R3: Each resolve shifts the 16-bit global history left by two. The new bit 1 is `rs_taken` and the new bit 0 is `rs_pc[2]`. Without a resolve, the history holds its value.
- R4: Every lookup pushes the current global history into a three-deep snapshot FIFO. The lookup is indexed by, and reports on `pred_hist`, the oldest entry present before the push, which is the history as it stood at the third-previous lookup.
- R5: Let w = pc[9:2]. The history of length L is folded by XORing bit i into bit i mod 8, for i < L. Each table index is rotl(w XOR fold, r), where (L, r) is (0,0) for bimodal, (13,1) for chooser, (8,3) for skew-A and (16,5) for skew-B. Tables hold 256 entries each.
- R6: The final prediction equals the majority of the bimodal, skew-A and skew-B direction bits when the chooser's direction bit is 1. Otherwise it equals the bimodal direction bit.
- R7: A counter step toward outcome d works as follows. If direction equals d, strength becomes 1. If direction differs and strength is 1, strength becomes 0. If direction differs and strength is 0, direction becomes d with strength 0. The direction bit is therefore rewritten only from a weak state.
- R8: The participants are the bimodal table alone when the chooser bit is 0, and otherwise the bimodal and both skew tables. These bits are re-read at resolve using `rs_pc` and `rs_hist`. If the final prediction matches the outcome, only participants that agreed with the outcome are stepped. Otherwise every participant is stepped toward the outcome.
- R9: The chooser counter is stepped only when the bimodal bit and the majority differ. It is stepped toward 1 if the majority matched the outcome, and toward 0 otherwise.
- R10: A lookup and a resolve in the same cycle are allowed. The lookup sees the counters and history as they were before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of branch to predict |
| rs_valid | input | 1 | Resolve (training) request |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_hist | input | 16 | History snapshot reported with that branch's prediction |
| pred_valid | output | 1 | Prediction present |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 16 | Lagged history that indexed this prediction |

## Verification
Each prediction is due exactly one cycle after its lookup is sampled. Training and history changes from a resolve take effect at that same edge, so they become visible only to lookups sampled later. The driver tags every expected item with the cycle in which it is due. The monitor samples on the falling edge and pops only the item whose due cycle has come, so a check never reads an output before its register has loaded. Because the reported history lags by three lookups, a change to the history made by a resolve is checked on the fourth lookup after it.

// File: rtl/skew_pred_pkg.sv
package skew_pred_pkg;

  localparam int NUM_TBL = 4;

  typedef enum int {
    TBL_BIM  = 0,
    TBL_META = 1,
    TBL_G0   = 2,
    TBL_G1   = 3
  } tbl_e;

  // One 2-bit saturating step toward dir; result is {dir_bit, strength}.
  function automatic logic [1:0] ctr_step(input logic p, input logic h, input logic dir);
    if (p == dir)  return {p, 1'b1};
    else if (h)    return {p, 1'b0};
    else           return {dir, 1'b0};
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/skew_hist_track.sv
module skew_hist_track #(
  parameter int HIST_W = 16,
  parameter int LAG    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              shift_en,
  input  logic [1:0]        shift_in,
  output logic [HIST_W-1:0] ghist,
  output logic [HIST_W-1:0] lag_hist
);

  logic [HIST_W-1:0] snap [LAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ghist <= '0;
    end else if (shift_en) begin
      ghist <= {ghist[HIST_W-3:0], shift_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAG; i++) snap[i] <= '0;
    end else if (push) begin
      snap[0] <= ghist;
      for (int i = 1; i < LAG; i++) snap[i] <= snap[i-1];
    end
  end

  assign lag_hist = snap[LAG-1];

endmodule

// File: rtl/skew_index_hash.sv
module skew_index_hash #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 16,
  parameter int HLEN   = 0,
  parameter int ROT    = 0
) (
  input  logic [IDX_W-1:0]  pc_word,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  localparam int R = ROT % IDX_W;

  logic [IDX_W-1:0] folded;
  logic [IDX_W-1:0] mixed;

  always_comb begin
    folded = '0;
    for (int i = 0; i < HIST_W; i++) begin
      if (i < HLEN) folded[i % IDX_W] = folded[i % IDX_W] ^ hist[i];
    end
    mixed = pc_word ^ folded;
    for (int i = 0; i < IDX_W; i++) idx[(i + R) % IDX_W] = mixed[i];
  end

endmodule

// File: rtl/skew_counter_bank.sv
module skew_counter_bank #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_p,
  input  logic [IDX_W-1:0] rs_idx,
  output logic             rs_p,
  output logic             rs_h,
  input  logic             wr_en,
  input  logic             wr_p,
  input  logic             wr_h
);

  localparam int ENTRIES = 1 << IDX_W;

  logic dir_mem [ENTRIES];
  logic hys_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) dir_mem[i] <= 1'b0;
    end else if (wr_en) begin
      dir_mem[rs_idx] <= wr_p;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) hys_mem[i] <= 1'b0;
    end else if (wr_en) begin
      hys_mem[rs_idx] <= wr_h;
    end
  end

  assign lk_p = dir_mem[lk_idx];
  assign rs_p = dir_mem[rs_idx];
  assign rs_h = hys_mem[rs_idx];

endmodule

// File: rtl/skew_vote_predictor.sv
module skew_vote_predictor
  import skew_pred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 8,
  parameter int HIST_W    = 16,
  parameter int LAG       = 3,
  parameter int HLEN_META = 13,
  parameter int HLEN_G0   = 8,
  parameter int HLEN_G1   = 16,
  parameter int ROT_META  = 1,
  parameter int ROT_G0    = 3,
  parameter int ROT_G1    = 5,
  parameter int PATH_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken,
  input  logic [HIST_W-1:0] rs_hist,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist
);

  localparam int PC_LSB = 2;

  logic [HIST_W-1:0] ghist;
  logic [HIST_W-1:0] lag_hist;

  logic [IDX_W-1:0] lk_idx [NUM_TBL];
  logic [IDX_W-1:0] rs_idx [NUM_TBL];
  logic [NUM_TBL-1:0] lk_p, rs_p, rs_h, wr_en, wr_p, wr_h;

  skew_hist_track #(.HIST_W(HIST_W), .LAG(LAG)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .push     (lk_valid),
    .shift_en (rs_valid),
    .shift_in ({rs_taken, rs_pc[PATH_BIT]}),
    .ghist    (ghist),
    .lag_hist (lag_hist)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    localparam int HL = (t == TBL_META) ? HLEN_META :
                        (t == TBL_G0)   ? HLEN_G0   :
                        (t == TBL_G1)   ? HLEN_G1   : 0;
    localparam int RT = (t == TBL_META) ? ROT_META :
                        (t == TBL_G0)   ? ROT_G0   :
                        (t == TBL_G1)   ? ROT_G1   : 0;

    skew_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W), .HLEN(HL), .ROT(RT)) u_lk_hash (
      .pc_word (lk_pc[PC_LSB +: IDX_W]),
      .hist    (lag_hist),
      .idx     (lk_idx[t])
    );

    skew_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W), .HLEN(HL), .ROT(RT)) u_rs_hash (
      .pc_word (rs_pc[PC_LSB +: IDX_W]),
      .hist    (rs_hist),
      .idx     (rs_idx[t])
    );

    skew_counter_bank #(.IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .lk_idx (lk_idx[t]),
      .lk_p   (lk_p[t]),
      .rs_idx (rs_idx[t]),
      .rs_p   (rs_p[t]),
      .rs_h   (rs_h[t]),
      .wr_en  (wr_en[t]),
      .wr_p   (wr_p[t]),
      .wr_h   (wr_h[t])
    );
  end

  // Lookup stage: vote and choose, then register.
  logic lk_maj, lk_final;
  always_comb begin
    lk_maj   = vote3(lk_p[TBL_BIM], lk_p[TBL_G0], lk_p[TBL_G1]);
    lk_final = lk_p[TBL_META] ? lk_maj : lk_p[TBL_BIM];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_taken <= lk_final;
        pred_hist  <= lag_hist;
      end
    end
  end

  // Resolve stage: re-read direction and strength, compute updates.
  logic rs_maj, rs_final, rs_miss;
  always_comb begin
    rs_maj   = vote3(rs_p[TBL_BIM], rs_p[TBL_G0], rs_p[TBL_G1]);
    rs_final = rs_p[TBL_META] ? rs_maj : rs_p[TBL_BIM];
    rs_miss  = (rs_final != rs_taken);
    wr_en    = '0;
    wr_p     = rs_p;
    wr_h     = rs_h;
    for (int t = 0; t < NUM_TBL; t++) begin
      if (t != TBL_META) begin
        if (rs_valid && ((t == TBL_BIM) || rs_p[TBL_META]) &&
            (rs_miss || (rs_p[t] == rs_taken))) begin
          wr_en[t] = 1'b1;
          {wr_p[t], wr_h[t]} = ctr_step(rs_p[t], rs_h[t], rs_taken);
        end
      end
    end
    if (rs_valid && (rs_p[TBL_BIM] != rs_maj)) begin
      wr_en[TBL_META] = 1'b1;
      {wr_p[TBL_META], wr_h[TBL_META]} =
        ctr_step(rs_p[TBL_META], rs_h[TBL_META], rs_maj == rs_taken);
    end
  end

endmodule

// File: rtl/skew_vote_predictor_chk.sv
module skew_vote_predictor_chk #(
  parameter int HIST_W = 16,
  parameter int LAG    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic              rs_pc_bit,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic [HIST_W-1:0] ghist
);

  logic       trained;
  logic [3:0] lk_since_rs;

  always_ff @(posedge clk) begin
    if (rst) begin
      trained     <= 1'b0;
      lk_since_rs <= '0;
    end else begin
      trained <= trained | rs_valid;
      if (rs_valid)                         lk_since_rs <= '0;
      else if (lk_valid && lk_since_rs < 4'd15) lk_since_rs <= lk_since_rs + 4'd1;
    end
  end

  AST_PRED_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2
  AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R2
  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> ghist[1:0] == {$past(rs_taken), $past(rs_pc_bit)}); // R3
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> $stable(ghist)); // R3
  AST_UNTRAINED_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !trained) |-> !pred_taken); // R1
  AST_LAG_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_since_rs >= 4'(LAG)) |=> pred_hist == $past(ghist)); // R4

endmodule

bind skew_vote_predictor skew_vote_predictor_chk #(.HIST_W(HIST_W), .LAG(LAG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .rs_valid   (rs_valid),
  .rs_taken   (rs_taken),
  .rs_pc_bit  (rs_pc[PATH_BIT]),
  .pred_valid (pred_valid),
  .pred_taken (pred_taken),
  .pred_hist  (pred_hist),
  .ghist      (ghist)
);

// File: tb/skew_vote_predictor_bench.sv
`timescale 1ns/1ps
module skew_vote_predictor_bench;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic [15:0] rs_hist = '0;
  logic        pred_valid;
  logic        pred_taken;
  logic [15:0] pred_hist;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  skew_vote_predictor u_skew_vote_predictor (
    .clk, .rst, .lk_valid, .lk_pc, .rs_valid, .rs_pc, .rs_taken, .rs_hist,
    .pred_valid, .pred_taken, .pred_hist
  );

  // Reference model built from the requirements.
  bit          m_dir [4][256];
  bit          m_hys [4][256];
  logic [15:0] m_g, m_s0, m_s1, m_s2;

  typedef struct {
    int          due;
    bit          v;
    bit          t;
    logic [15:0] h;
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic int mhash(int t, logic [31:0] pc, logic [15:0] h);
    int len, rot;
    logic [7:0] w, f, x, o;
    len = (t == 1) ? 13 : (t == 2) ? 8 : (t == 3) ? 16 : 0;
    rot = (t == 1) ? 1 : (t == 2) ? 3 : (t == 3) ? 5 : 0;
    w = pc[9:2];
    f = '0;
    for (int i = 0; i < 16; i++) if (i < len) f[i % 8] ^= h[i];
    x = w ^ f;
    for (int i = 0; i < 8; i++) o[(i + rot) % 8] = x[i];
    return int'(o);
  endfunction

  function automatic void mstep(int t, int ix, bit d);
    if (m_dir[t][ix] == d)  m_hys[t][ix] = 1;
    else if (m_hys[t][ix])  m_hys[t][ix] = 0;
    else begin m_dir[t][ix] = d; m_hys[t][ix] = 0; end
  endfunction

  function automatic void model_reset();
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 256; i++) begin m_dir[t][i] = 0; m_hys[t][i] = 0; end
    m_g = '0; m_s0 = '0; m_s1 = '0; m_s2 = '0;
  endfunction

  task automatic step(input bit lv, input logic [31:0] lpc,
                      input bit rv, input logic [31:0] rpc, input bit rt,
                      input logic [15:0] rh, output logic [15:0] used);
    exp_t e;
    int ix[4];
    bit p[4];
    bit maj, fin, miss;
    @(posedge clk); #1;
    lk_valid = lv; lk_pc = lpc;
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_hist = rh;
    e.due = cyc + 1; e.v = lv; e.t = 0; e.h = '0; e.tag = cur_tag;
    used = m_s2;
    if (lv) begin
      for (int t = 0; t < 4; t++) p[t] = m_dir[t][mhash(t, lpc, m_s2)];
      maj = (p[0] & p[2]) | (p[0] & p[3]) | (p[2] & p[3]);
      e.t = p[1] ? maj : p[0];
      e.h = m_s2;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = m_g;    // R4 push before resolve (R10)
    end
    sb.push_back(e);
    if (rv) begin
      for (int t = 0; t < 4; t++) begin ix[t] = mhash(t, rpc, rh); p[t] = m_dir[t][ix[t]]; end
      maj  = (p[0] & p[2]) | (p[0] & p[3]) | (p[2] & p[3]);
      fin  = p[1] ? maj : p[0];
      miss = (fin != rt);
      for (int t = 0; t < 4; t++) begin
        if (t != 1 && (t == 0 || p[1]) && (miss || p[t] == rt)) mstep(t, ix[t], rt); // R7 R8
      end
      if (p[0] != maj) mstep(1, ix[1], maj == rt);                                   // R9
      m_g = {m_g[13:0], rt, rpc[2]};                                                  // R3
    end
  endtask

  task automatic idle();
    logic [15:0] u;
    step(0, '0, 0, '0, 0, '0, u);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1; lk_valid = 0; rs_valid = 0;
    sb.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pred_valid !== 1'b0 || pred_taken !== 1'b0 || pred_hist !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset outputs valid=%b taken=%b hist=%h expected 0 0 0000",
               pred_valid, pred_taken, pred_hist);
    end
    model_reset();
    @(posedge clk); #1;
    rst = 0;
  endtask

  // Monitor: compare the item whose due cycle has arrived.
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pred_valid !== e.v) begin
          errors++;
          $display("FAIL R2 pred_valid=%b expected %b at cycle %0d", pred_valid, e.v, cyc);
        end else if (e.v) begin
          checks++;
          if (pred_hist !== e.h) begin
            errors++;
            $display("FAIL R4 pred_hist=%h expected %h (%s)", pred_hist, e.h, e.tag);
          end
          checks++;
          if (pred_taken !== e.t) begin
            errors++;
            $display("FAIL %s pred_taken=%b expected %b at cycle %0d", e.tag, pred_taken, e.t, cyc);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 2 * HALF);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] h, ph;
    logic [31:0] pend_pc, npc;
    bit          pend, out;
    logic [31:0] pcs [8];
    for (int i = 0; i < 8; i++) pcs[i] = 32'h1000 + 32'(i * 52);

    do_reset();

    // R1: untrained lookups, various addresses
    cur_tag = "R1";
    for (int i = 0; i < 5; i++) step(1, 32'h40 + 32'(i * 36), 0, '0, 0, '0, h);
    idle();

    // R7: one branch trained taken then not-taken, direction flips only when weak
    cur_tag = "R7";
    for (int k = 0; k < 6; k++) begin
      step(1, 32'h200, 0, '0, 0, '0, h);
      idle();
      step(0, '0, 1, 32'h200, (k < 3), h, ph);
      idle();
    end

    // R3: history shift with outcome and path bit, seen on the fourth lookup
    do_reset();
    cur_tag = "R3";
    step(0, '0, 1, 32'h4, 1, '0, h);
    for (int i = 0; i < 4; i++) step(1, 32'h80, 0, '0, 0, '0, h);
    step(0, '0, 1, 32'h0, 0, '0, h);
    step(0, '0, 1, 32'h4, 0, '0, h);
    for (int i = 0; i < 4; i++) step(1, 32'h84, 0, '0, 0, '0, h);
    idle();

    // R10: lookup and resolve of the same branch in one cycle
    cur_tag = "R10";
    for (int k = 0; k < 4; k++) begin
      step(1, 32'h300, 0, '0, 0, '0, h);
      step(1, 32'h300, 1, 32'h300, 1, h, ph);
      step(1, 32'h300, 1, 32'h300, 1, ph, h);
    end
    idle();

    // R5 R6 R8 R9: pipelined mixed patterns, each branch resolved one cycle after lookup
    do_reset();
    cur_tag = "R5 R6 R8 R9";
    pend = 0; pend_pc = '0; ph = '0;
    for (int n = 0; n < 1500; n++) begin
      npc = pcs[$urandom_range(7)];
      case (pend_pc[4:2] % 4)
        0: out = 1;
        1: out = 0;
        2: out = ph[1] ^ ph[3];
        default: out = ($urandom_range(3) != 0);
      endcase
      step(1, npc, pend, pend_pc, out, ph, h);
      pend = 1; pend_pc = npc; ph = h;
      if (n % 97 == 0) idle();
    end
    idle(); idle();

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 %0d expected predictions never arrived, expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule